// File: doc/BRIEF.md
# Dual-Channel Serial ADC Capture Controller

This block is the FPGA-side bus master for a two-channel serial converter that samples both of its analog inputs at the same instant. On a fixed schedule it raises a one-clock conversion strobe and then runs a fixed frame of serial clock cycles. During that frame it shifts two 14-bit two's complement results in from the MISO line. At the end of the frame it presents both results together, sign-extended, with a one-cycle valid pulse.

The converter always returns the result of the conversion started by the strobe before the current one. For this reason, the first frame after reset or after enable carries no real data, and its valid pulse is withheld. The strobe period is set by a parameter. The block raises it to the longest of the requested period, the converter's maximum rate limit and the frame length, so the converter is never driven too fast. The serial clock and MISO lines are shared with other devices. The block holds their active-low selects deasserted.

Top module: `adc_pair_capture`

## Requirements
- R1: A synchronous active-high `rst` returns the block to idle on the next clock: `conv`, `sclk` and `valid` low and both channel outputs zero.
- R2: `conv` is high for exactly one system clock. It first rises on the clock edge that samples `rst` low and `enable` high. It then repeats every effective period P while both conditions hold.
- R3: In the P-cycle schedule, counted from the strobe cycle as 0, cycles 1 to 2·(L+14)·2·D form the frame, where D is `SCLK_DIV` and L is `LEAD_BITS`. Each bit drives `sclk` low for D cycles and then high for D cycles. `sclk` is low outside the frame.
- R4: MISO is captured on the system edge that raises `sclk`. The frame carries, most significant bit first: L ignored bits, channel A's 14 bits, L ignored bits, then channel B's 14 bits.
- R5: `valid` is a single-cycle pulse in schedule cycle 2·(L+14)·2·D + 1. With the default settings this is 129 cycles after the strobe cycle.
- R6: The pair presented with `valid` is the one the converter returned in that frame, which belongs to the previous strobe. The first frame after reset or after `enable` rises produces no `valid`.
- R7: `ch_a` and `ch_b` are the 14-bit fields sign-extended to `OUT_W` bits. They hold their value between valid pulses.
- R8: Every bit of `other_cs_n` is high at all times.
- R9: P = max(`CONV_PERIOD`, ceil(`SYS_CLK_HZ`/`MAX_RATE_HZ`), frame length + 2). With a 125 MHz clock and a 1.5 MHz limit the floor is 84 cycles, so a request of 20 with D=1 and L=1 runs at 84.
- R10: With `enable` low the block is idle from the next cycle on: no strobe, `sclk` low and no `valid`. A frame in progress is abandoned without a valid pulse, and the channel outputs keep their last values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| enable | input | 1 | Run conversions while high |
| miso | input | 1 | Serial data from the converter |
| conv | output | 1 | Conversion-start strobe, one clock wide |
| sclk | output | 1 | Serial clock to the converter |
| other_cs_n | output | N_OTHER | Active-low selects of other bus devices, held high |
| ch_a | output | OUT_W | Channel A result, sign-extended |
| ch_b | output | OUT_W | Channel B result, sign-extended |
| valid | output | 1 | One-cycle pulse when a new pair is presented |

## Verification
The hardest situation to reach from the ports is the interplay of the one-sample latency with a session restart. The bench has to show three things. The first frame after enable or reset never produces a valid pulse. A frame cut short by `enable` falling produces nothing. The data after a restart belongs to the strobe before it, not to any value left from the earlier session. The bench gets there by acting as the converter: at each strobe it draws a fresh pair and sends the pair from the previous strobe, including the extreme codes 0x2000, 0x1FFF and 0x3FFF. It drops `enable` and then `rst` in the middle of a frame. A second instance with a very short requested period shows that the rate floor, not the request, sets the strobe spacing.

// File: rtl/adc_cap_pkg.sv
package adc_cap_pkg;

  localparam int SAMPLE_W = 14;

  function automatic int ceil_div(input int num, input int den);
    return (num + den - 1) / den;
  endfunction

  function automatic int max2(input int a, input int b);
    return (a > b) ? a : b;
  endfunction

  // Total system clocks occupied by the serial frame (both fields).
  function automatic int frame_clks(input int half_div, input int lead);
    return 2 * (lead + SAMPLE_W) * 2 * half_div;
  endfunction

  // Strobe spacing actually used: never faster than the rate limit
  // and never shorter than the frame plus strobe and result cycles.
  function automatic int eff_period(input int req, input int sys_hz,
                                    input int max_hz, input int half_div,
                                    input int lead);
    return max2(max2(req, ceil_div(sys_hz, max_hz)),
                frame_clks(half_div, lead) + 2);
  endfunction

endpackage

// File: rtl/adc_cap_timer.sv
module adc_cap_timer #(
  parameter int PERIOD     = 150,
  parameter int FRAME_CLKS = 128,
  parameter int HALF       = 2
) (
  input  logic clk,
  input  logic hold,
  output logic conv,
  output logic sclk,
  output logic cap_evt,
  output logic end_evt
);
  localparam int CW     = $clog2(PERIOD);
  localparam int BITCLK = 2 * HALF;
  localparam int PW     = $clog2(BITCLK);

  logic [CW-1:0] slot;
  logic [PW-1:0] phase;
  logic          in_frame;

  assign in_frame = (slot != '0) && (slot <= CW'(FRAME_CLKS));
  assign cap_evt  = in_frame && (phase == PW'(HALF));
  assign end_evt  = (slot == CW'(FRAME_CLKS + 1));

  always_ff @(posedge clk) begin
    if (hold) begin
      slot  <= '0;
      phase <= '0;
      conv  <= 1'b0;
      sclk  <= 1'b0;
    end else begin
      slot <= (slot == CW'(PERIOD - 1)) ? '0 : slot + 1'b1;
      conv <= (slot == '0);
      if (in_frame) begin
        sclk  <= (phase >= PW'(HALF));
        phase <= (phase == PW'(BITCLK - 1)) ? '0 : phase + 1'b1;
      end else begin
        sclk  <= 1'b0;
        phase <= '0;
      end
    end
  end
endmodule

// File: rtl/adc_cap_shifter.sv
module adc_cap_shifter #(
  parameter int SW   = 14,
  parameter int LEAD = 2
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          shift_en,
  input  logic          din,
  output logic [SW-1:0] field_a,
  output logic [SW-1:0] field_b
);
  localparam int KEEP = 2 * SW + LEAD;

  logic [KEEP-1:0] sreg;

  always_ff @(posedge clk) begin
    if (rst)           sreg <= '0;
    else if (shift_en) sreg <= {sreg[KEEP-2:0], din};
  end

  assign field_a = sreg[KEEP-1 -: SW];
  assign field_b = sreg[SW-1:0];
endmodule

// File: rtl/adc_cap_out.sv
module adc_cap_out #(
  parameter int SW = 14,
  parameter int OW = 16
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          hold,
  input  logic          end_evt,
  input  logic [SW-1:0] field_a,
  input  logic [SW-1:0] field_b,
  output logic [OW-1:0] ch_a,
  output logic [OW-1:0] ch_b,
  output logic          valid
);
  logic prime;
  logic publish;

  assign publish = end_evt && !prime;

  always_ff @(posedge clk) begin
    if (hold) begin
      prime <= 1'b1;
      valid <= 1'b0;
    end else begin
      valid <= publish;
      if (end_evt) prime <= 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      ch_a <= '0;
      ch_b <= '0;
    end else if (!hold && publish) begin
      ch_a <= {{(OW-SW){field_a[SW-1]}}, field_a};
      ch_b <= {{(OW-SW){field_b[SW-1]}}, field_b};
    end
  end
endmodule

// File: rtl/adc_pair_capture.sv
module adc_pair_capture
  import adc_cap_pkg::*;
#(
  parameter int SYS_CLK_HZ  = 125_000_000,
  parameter int MAX_RATE_HZ = 1_500_000,
  parameter int SCLK_DIV    = 2,
  parameter int LEAD_BITS   = 2,
  parameter int CONV_PERIOD = 150,
  parameter int OUT_W       = 16,
  parameter int N_OTHER     = 2
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               enable,
  input  logic               miso,
  output logic               conv,
  output logic               sclk,
  output logic [N_OTHER-1:0] other_cs_n,
  output logic [OUT_W-1:0]   ch_a,
  output logic [OUT_W-1:0]   ch_b,
  output logic               valid
);
  localparam int SW         = SAMPLE_W;
  localparam int FRAME_CLKS = frame_clks(SCLK_DIV, LEAD_BITS);
  localparam int PERIOD     = eff_period(CONV_PERIOD, SYS_CLK_HZ, MAX_RATE_HZ,
                                         SCLK_DIV, LEAD_BITS);

  // Named internal events, visible to the bound checker.
  logic          hold;
  logic          cap_evt;
  logic          end_evt;
  logic [SW-1:0] field_a;
  logic [SW-1:0] field_b;

  assign hold       = rst | ~enable;
  assign other_cs_n = '1;

  adc_cap_timer #(
    .PERIOD    (PERIOD),
    .FRAME_CLKS(FRAME_CLKS),
    .HALF      (SCLK_DIV)
  ) u_timer (
    .clk    (clk),
    .hold   (hold),
    .conv   (conv),
    .sclk   (sclk),
    .cap_evt(cap_evt),
    .end_evt(end_evt)
  );

  adc_cap_shifter #(
    .SW  (SW),
    .LEAD(LEAD_BITS)
  ) u_shift (
    .clk     (clk),
    .rst     (rst),
    .shift_en(cap_evt),
    .din     (miso),
    .field_a (field_a),
    .field_b (field_b)
  );

  adc_cap_out #(
    .SW(SW),
    .OW(OUT_W)
  ) u_out (
    .clk    (clk),
    .rst    (rst),
    .hold   (hold),
    .end_evt(end_evt),
    .field_a(field_a),
    .field_b(field_b),
    .ch_a   (ch_a),
    .ch_b   (ch_b),
    .valid  (valid)
  );
endmodule

// File: rtl/adc_pair_capture_chk.sv
module adc_pair_capture_chk #(
  parameter int SYS_CLK_HZ  = 125_000_000,
  parameter int MAX_RATE_HZ = 1_500_000,
  parameter int OUT_W       = 16
) (
  input logic             clk,
  input logic             rst,
  input logic             enable,
  input logic             conv,
  input logic             sclk,
  input logic             valid,
  input logic [OUT_W-1:0] ch_a,
  input logic [OUT_W-1:0] ch_b
);
  localparam int MIN_GAP = (SYS_CLK_HZ + MAX_RATE_HZ - 1) / MAX_RATE_HZ;

  int unsigned gap;
  logic        seen;

  always_ff @(posedge clk) begin
    if (rst || !enable) begin
      gap  <= 0;
      seen <= 1'b0;
    end else if (conv) begin
      gap  <= 1;
      seen <= 1'b1;
    end else if (gap < 32'h7fff_ffff) begin
      gap <= gap + 1;
    end
  end

  a_r2_conv_single: assert property (@(posedge clk) disable iff (rst)
    conv |=> !conv);

  a_r3_sclk_low_at_strobe: assert property (@(posedge clk) disable iff (rst)
    conv |-> !sclk);

  a_r5_valid_single: assert property (@(posedge clk) disable iff (rst)
    valid |=> !valid);

  a_r7_sign_extended: assert property (@(posedge clk) disable iff (rst)
    valid |-> (ch_a[OUT_W-1:13] == {(OUT_W-13){ch_a[13]}} &&
               ch_b[OUT_W-1:13] == {(OUT_W-13){ch_b[13]}}));

  a_r9_rate_floor: assert property (@(posedge clk) disable iff (rst)
    (conv && seen) |-> (gap >= MIN_GAP));

  a_r10_disable_idle: assert property (@(posedge clk) disable iff (rst)
    !enable |=> (!conv && !sclk && !valid));
endmodule

bind adc_pair_capture adc_pair_capture_chk #(
  .SYS_CLK_HZ (SYS_CLK_HZ),
  .MAX_RATE_HZ(MAX_RATE_HZ),
  .OUT_W      (OUT_W)
) u_chk (
  .clk   (clk),
  .rst   (rst),
  .enable(enable),
  .conv  (conv),
  .sclk  (sclk),
  .valid (valid),
  .ch_a  (ch_a),
  .ch_b  (ch_b)
);

// File: tb/adc_pair_capture_bench.sv
module adc_pair_capture_bench;
  localparam int SYS   = 125_000_000;
  localparam int RATE  = 1_500_000;
  localparam int DIV   = 2;
  localparam int LEAD  = 2;
  localparam int REQ   = 150;
  localparam int FLD   = LEAD + 14;
  localparam int NBITS = 2 * FLD;
  localparam int FR    = NBITS * 2 * DIV;
  localparam int FLOOR = (SYS + RATE - 1) / RATE;
  localparam int EFF   = (REQ > FLOOR ? REQ : FLOOR) > FR + 2 ?
                         (REQ > FLOOR ? REQ : FLOOR) : FR + 2;
  // second instance: short request, rate floor must win
  localparam int REQ2  = 20;
  localparam int FR2   = 2 * (1 + 14) * 2 * 1;
  localparam int EFF2  = (REQ2 > FLOOR ? REQ2 : FLOOR) > FR2 + 2 ?
                         (REQ2 > FLOOR ? REQ2 : FLOOR) : FR2 + 2;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic enable = 1'b0;
  logic miso = 1'b0;
  always #4 clk = ~clk;

  logic        conv, sclk, valid, conv2, sclk2, valid2;
  logic [1:0]  cs_n, cs_n2;
  logic [15:0] ch_a, ch_b, ch_a2, ch_b2;

  adc_pair_capture u_adc_pair_capture (
    .clk(clk), .rst(rst), .enable(enable), .miso(miso),
    .conv(conv), .sclk(sclk), .other_cs_n(cs_n),
    .ch_a(ch_a), .ch_b(ch_b), .valid(valid));

  adc_pair_capture #(.SCLK_DIV(1), .LEAD_BITS(1), .CONV_PERIOD(REQ2)) u_fast (
    .clk(clk), .rst(rst), .enable(enable), .miso(miso),
    .conv(conv2), .sclk(sclk2), .other_cs_n(cs_n2),
    .ch_a(ch_a2), .ch_b(ch_b2), .valid(valid2));

  int   errs = 0;
  int   checks = 0;
  int   k = 0;
  int   cyc = 0;
  int   last2 = -1;
  int   bc = 0;
  int   scount = 0;
  logic rst_s = 1'b1;
  logic en_s = 1'b0;
  logic pse = 1'b0;
  logic done = 1'b0;
  logic [13:0] sa = 14'h0, sb = 14'h0, tx_a = 14'h0, tx_b = 14'h0;
  logic [15:0] ea = 16'h0, eb = 16'h0;

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errs++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
    end
  endtask

  function automatic logic [15:0] widen(input logic [13:0] v);
    logic signed [15:0] r;
    r = $signed(v);
    return r;
  endfunction

  function automatic logic bit_for(input int b);
    int f, o;
    logic [13:0] v;
    if (b >= NBITS) return 1'($urandom);
    f = b / FLD;
    o = b % FLD;
    if (o < LEAD) return 1'($urandom);
    v = (f == 0) ? tx_a : tx_b;
    return v[13 - (o - LEAD)];
  endfunction

  task automatic finish_run();
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  endtask

  // Session bookkeeping from inputs sampled at the clock edge.
  always @(posedge clk) begin
    rst_s <= rst;
    en_s  <= enable;
    if (rst || !enable) k <= 0;
    else                k <= k + 1;
    if (rst) begin
      ea <= 16'h0;
      eb <= 16'h0;
    end
  end

  // Reference model, compared at every falling edge; also plays the converter.
  always @(negedge clk) begin
    int j, n;
    logic ce, se, ve;
    string pfx;
    if (!done) begin
      cyc++;
      ce = 1'b0; se = 1'b0; ve = 1'b0; j = 0; n = 0;
      if (k > 0) begin
        j  = (k - 1) % EFF;
        n  = (k - 1) / EFF;
        ce = (j == 0);
        se = (j >= 1) && (j <= FR) && (((j - 1) % (2 * DIV)) >= DIV);
        ve = (j == FR + 1) && (n >= 1);
      end
      if (ce) begin
        tx_a = sa; tx_b = sb; bc = 0; pse = 1'b0;
        scount++;
        if (scount % 7 == 2)      begin sa = 14'h2000; sb = 14'h1FFF; end
        else if (scount % 7 == 4) begin sa = 14'h0000; sb = 14'h3FFF; end
        else begin sa = 14'($urandom); sb = 14'($urandom); end
      end
      if (ve) begin ea = widen(tx_a); eb = widen(tx_b); end

      pfx = rst_s ? "R1" : (!en_s ? "R10" : "");
      chk({pfx == "" ? "R2" : pfx, " conv"}, 32'(conv), 32'(ce));
      chk({pfx == "" ? "R3" : pfx, " sclk"}, 32'(sclk), 32'(se));
      chk({pfx == "" ? "R5/R6" : pfx, " valid"}, 32'(valid), 32'(ve));
      chk({pfx == "" ? "R4/R6/R7" : pfx, " ch_a"}, 32'(ch_a), 32'(ea));
      chk({pfx == "" ? "R4/R6/R7" : pfx, " ch_b"}, 32'(ch_b), 32'(eb));
      chk("R8 other_cs_n", 32'(cs_n & cs_n2), 32'h3);

      // converter model: data moves only while sclk is low
      if (se && !pse) bc++;
      pse = se;
      if (!se) miso = bit_for(bc);

      // strobe spacing of the short-request instance
      if (k == 0) last2 = -1;
      else if (conv2) begin
        if (last2 >= 0) chk("R9 strobe spacing", 32'(cyc - last2), 32'(EFF2));
        last2 = cyc;
      end
    end
  end

  initial begin
    rst = 1'b1;
    enable = 1'b1;
    repeat (5) @(negedge clk);
    rst = 1'b0;
    repeat (EFF * 10 + 40) @(negedge clk);
    enable = 1'b0;                 // R10: abandon a frame mid-way
    repeat (60) @(negedge clk);
    enable = 1'b1;
    repeat (EFF * 5 + 70) @(negedge clk);
    rst = 1'b1;                    // R1: reset mid-frame
    repeat (3) @(negedge clk);
    rst = 1'b0;
    repeat (EFF * 4 + 10) @(negedge clk);
    done = 1'b1;
    finish_run();
  end

  initial begin
    repeat (100000) @(posedge clk);
    done = 1'b1;
    errs++;
    checks++;
    $display("FAIL R2 watchdog expired actual=running expected=finished");
    finish_run();
  end
endmodule